// File: doc/BRIEF.md
# Supply Overvoltage Shutdown and Retry Controller

This block sits between the command register of a multi-channel low-side switch and its output drivers. It watches a digital flag from a supply comparator. Before it acts, it requires the flag to be held for longer than a programmable time window, measured in system clock cycles. Once the overvoltage is confirmed, every output channel is forced off for as long as the flag stays high.

When the flag drops, one control bit selects the recovery. With retry enabled, the commanded outputs come back at once. With retry disabled, the outputs stay off until software writes a new command or the block is reset.

The block also produces an overvoltage fault flag, which holds until it is read after the condition has gone. That flag is merged with a load-fault summary into an any-fault flag. A short glitch on the comparator, or a burst that ends before the window expires, changes nothing at the outputs.

Top module: `ovp_shutdown_ctrl`

## Requirements
- R1: While `rstN` is low, `outVec` is all zeros and `ovFault` is 0. After release the block starts in the normal state with an empty qualification count.
- R2: In the normal state, `outVec` equals the value of `cmdOut` sampled at the previous rising clock edge.
- R3: When `ovRaw` is sampled high on QUAL_CYCLES+1 consecutive rising edges (QUAL_CYCLES = CLK_HZ/1e6 × QUAL_US, 5000 by default), `outVec` is all zeros after the last of those edges. A run of exactly QUAL_CYCLES high samples followed by a low sample leaves the outputs on.
- R4: A single low sample of `ovRaw` restarts qualification, so a later shutdown needs a fresh run of QUAL_CYCLES+1 consecutive high samples.
- R5: During shutdown, `outVec` stays all zeros whatever `cmdOut` does.
- R6: In shutdown with `retryEn` high, the first edge that samples `ovRaw` low restores `outVec` to the `cmdOut` sampled at that edge.
- R7: In shutdown with `retryEn` low, the edge that samples `ovRaw` low moves the block to a locked-off state. `outVec` stays all zeros there until an edge samples `cmdWrite` high, which restores `cmdOut`.
- R8: `ovFault` becomes 1 at the edge that confirms the overvoltage.
- R9: `ovFault` clears only at an edge that samples `statusRead` high while `ovRaw` is low and the block is not in shutdown. A read during overvoltage leaves it set.
- R10: `anyFault` is the OR of `ovFault` and the `loadFault` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ovRaw | input | 1 | Comparator flag, high while the supply is over the limit |
| retryEn | input | 1 | 1 = automatic recovery, 0 = stay off until a new command |
| cmdWrite | input | 1 | One-cycle strobe marking a new command write |
| cmdOut | input | 16 | Commanded output vector |
| statusRead | input | 1 | One-cycle strobe marking a status readout |
| loadFault | input | 1 | Summary of per-channel load faults |
| outVec | output | 16 | Gated output vector to the drivers |
| ovFault | output | 1 | Latched overvoltage fault flag |
| anyFault | output | 1 | OR of all fault sources |

## Verification
The bench aims at the edges of the qualification window. A run of exactly QUAL_CYCLES high samples must not shut down, while one more sample must. A design with an off-by-one counter would trip early or late. A one-cycle dip inside a long burst must restart the count; a design that only pauses the count would shut down too soon. The bench exercises both recovery settings, changes the command while outputs are forced off, and issues status reads during and after the condition. A design that cleared the fault flag too eagerly, or that released the locked state without a command write, would show up as a mismatch against the reference model.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_QUAL   = 2'd1,
    ST_SHUT   = 2'd2,
    ST_LOCK   = 2'd3
  } ovState_t;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic forceOff;
    logic setFault;
    logic clrFault;
  } ovStrobe_t;

endpackage

// File: rtl/ovp_ctrl.sv
module ovp_ctrl
  import ovp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ovRaw,
  input  logic      retryEn,
  input  logic      cmdWrite,
  input  logic      statusRead,
  input  logic      cntDone,
  output ovStrobe_t strobes,
  output ovState_t  stateQ
);

  ovState_t stateNext;

  always_comb begin
    stateNext = stateQ;
    strobes   = '0;
    unique case (stateQ)
      ST_NORMAL: begin
        if (ovRaw) begin
          stateNext      = ST_QUAL;
          strobes.cntInc = 1'b1;
        end else begin
          strobes.cntClear = 1'b1;
        end
      end
      ST_QUAL: begin
        if (!ovRaw) begin
          stateNext        = ST_NORMAL;
          strobes.cntClear = 1'b1;
        end else if (cntDone) begin
          stateNext        = ST_SHUT;
          strobes.setFault = 1'b1;
          strobes.cntClear = 1'b1;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      ST_SHUT: begin
        strobes.cntClear = 1'b1;
        if (!ovRaw) stateNext = retryEn ? ST_NORMAL : ST_LOCK;
      end
      ST_LOCK: begin
        strobes.cntClear = 1'b1;
        if (cmdWrite) stateNext = ST_NORMAL;
      end
      default: stateNext = ST_NORMAL;
    endcase
    strobes.forceOff = (stateNext == ST_SHUT) || (stateNext == ST_LOCK);
    strobes.clrFault = statusRead && !ovRaw && (stateQ != ST_SHUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_NORMAL;
    else       stateQ <= stateNext;
  end

  // R3: shutdown is only reachable through the qualifying state
  assert_no_skip_qual_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NORMAL) |=> (stateQ != ST_SHUT));

  // R7: locked-off state is left only on a command write
  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOCK && !cmdWrite) |=> (stateQ == ST_LOCK));

endmodule

// File: rtl/ovp_datapath.sv
module ovp_datapath
  import ovp_pkg::*;
#(
  parameter int NUM_OUT     = 16,
  parameter int QUAL_CYCLES = 5000,
  localparam int CW = $clog2(QUAL_CYCLES + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ovRaw,
  input  ovStrobe_t          strobes,
  input  logic [NUM_OUT-1:0] cmdOut,
  input  logic               loadFault,
  output logic               cntDone,
  output logic [NUM_OUT-1:0] outVec,
  output logic               ovFault,
  output logic               anyFault
);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cntQ <= '0;
    else if (strobes.cntClear)  cntQ <= '0;
    else if (strobes.cntInc)    cntQ <= cntQ + 1'b1;
  end

  assign cntDone = (cntQ == CW'(QUAL_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outVec <= '0;
    else if (strobes.forceOff) outVec <= '0;
    else                       outVec <= cmdOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovFault <= 1'b0;
    else if (strobes.setFault) ovFault <= 1'b1;
    else if (strobes.clrFault) ovFault <= 1'b0;
  end

  assign anyFault = ovFault | loadFault;

  // R3: qualification count never runs past its window
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CW'(QUAL_CYCLES));

  // R4: a low comparator sample empties the count
  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ovRaw |=> (cntQ == '0));

  // R9: fault flag cannot drop while the comparator is high
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovFault && ovRaw) |=> ovFault);

endmodule

// File: rtl/ovp_shutdown_ctrl.sv
module ovp_shutdown_ctrl
  import ovp_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int CLK_HZ  = 100_000_000,
  parameter int QUAL_US = 50,
  localparam int QUAL_CYCLES = (CLK_HZ / 1_000_000) * QUAL_US
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ovRaw,
  input  logic               retryEn,
  input  logic               cmdWrite,
  input  logic [NUM_OUT-1:0] cmdOut,
  input  logic               statusRead,
  input  logic               loadFault,
  output logic [NUM_OUT-1:0] outVec,
  output logic               ovFault,
  output logic               anyFault
);

  ovStrobe_t strobes;
  ovState_t  stateQ;
  logic      cntDone;

  ovp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ovRaw      (ovRaw),
    .retryEn    (retryEn),
    .cmdWrite   (cmdWrite),
    .statusRead (statusRead),
    .cntDone    (cntDone),
    .strobes    (strobes),
    .stateQ     (stateQ)
  );

  ovp_datapath #(
    .NUM_OUT     (NUM_OUT),
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ovRaw     (ovRaw),
    .strobes   (strobes),
    .cmdOut    (cmdOut),
    .loadFault (loadFault),
    .cntDone   (cntDone),
    .outVec    (outVec),
    .ovFault   (ovFault),
    .anyFault  (anyFault)
  );

  // R5: outputs are dark whenever the block sits in shutdown or lock
  assert_off_in_shutdown_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SHUT || stateQ == ST_LOCK) |-> (outVec == '0));

  // R8: being shut down implies the fault flag is raised
  assert_fault_with_shutdown_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SHUT) |-> ovFault);

endmodule

// File: tb/test_ovp_shutdown_ctrl.sv
`timescale 1ns/1ps
module test_ovp_shutdown_ctrl;

  localparam int N  = 5000;
  localparam int NO = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ovRaw = 1'b0, retryEn = 1'b1, cmdWrite = 1'b0;
  logic          statusRead = 1'b0, loadFault = 1'b0;
  logic [NO-1:0] cmdOut = 16'h0000;
  logic [NO-1:0] outVec;
  logic          ovFault, anyFault;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state: 0 normal, 1 qualifying, 2 shutdown, 3 locked
  int            mState = 0, mCnt = 0;
  logic          mFault = 1'b0;
  logic [NO-1:0] mOut = '0;

  always #5 clk = ~clk;

  ovp_shutdown_ctrl i_ovp_shutdown_ctrl (
    .clk(clk), .rstN(rstN), .ovRaw(ovRaw), .retryEn(retryEn),
    .cmdWrite(cmdWrite), .cmdOut(cmdOut), .statusRead(statusRead),
    .loadFault(loadFault), .outVec(outVec), .ovFault(ovFault),
    .anyFault(anyFault)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mFault = 1'b0; mOut = '0;
    end else begin
      int old;
      old = mState;
      if (statusRead && !ovRaw && old != 2) mFault = 1'b0;
      case (old)
        0: if (ovRaw) begin mState = 1; mCnt = 1; end else mCnt = 0;
        1: if (!ovRaw) begin mState = 0; mCnt = 0; end
           else if (mCnt == N) begin mState = 2; mCnt = 0; mFault = 1'b1; end
           else mCnt = mCnt + 1;
        2: if (!ovRaw) mState = retryEn ? 0 : 3;
        default: if (cmdWrite) mState = 0;
      endcase
      mOut = (mState >= 2) ? '0 : cmdOut;
    end
  end

  task automatic expect16(string tag, logic [NO-1:0] act, logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      expect16(mState == 2 ? "R5" : (mState == 3 ? "R7" : "R2"), outVec, mOut);
      expect1("R8", ovFault, mFault);
      expect1("R10", anyFault, mFault | loadFault);
    end
  end

  task automatic steps(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle;
    #2;
  endtask

  initial begin
    #1_900_000;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cmdOut = 16'hA5C3;
    steps(3); settle;
    expect16("R1 reset outputs", outVec, '0);
    expect1("R1 reset fault", ovFault, 1'b0);
    rstN = 1'b1;
    steps(2); settle;
    expect16("R2 pass-through", outVec, 16'hA5C3);
    cmdOut = 16'h1234; steps(1); settle;
    expect16("R2 pattern", outVec, 16'h1234);
    cmdOut = 16'hFFFF; steps(1);
    cmdOut = 16'h0001; steps(1); settle;
    expect16("R2 walking", outVec, 16'h0001);

    // exactly N high samples: no shutdown
    ovRaw = 1'b1; steps(N);
    ovRaw = 1'b0; steps(1); settle;
    expect16("R3 near-miss stays on", outVec, 16'h0001);
    expect1("R3 near-miss no fault", ovFault, 1'b0);

    // glitch inside a burst restarts the count
    ovRaw = 1'b1; steps(N - 10);
    ovRaw = 1'b0; steps(1);
    ovRaw = 1'b1; steps(N); settle;
    expect16("R4 restart keeps on", outVec, 16'h0001);
    steps(1); settle;
    expect16("R3 shutdown after N+1", outVec, '0);
    expect1("R8 fault set", ovFault, 1'b1);
    expect1("R10 any fault", anyFault, 1'b1);

    // shutdown holds through command changes and reads
    cmdOut = 16'hBEEF; statusRead = 1'b1; steps(1);
    statusRead = 1'b0; steps(3); settle;
    expect16("R5 forced off", outVec, '0);
    expect1("R9 read during ov keeps fault", ovFault, 1'b1);

    // retry enabled: resume
    retryEn = 1'b1; ovRaw = 1'b0; steps(1); settle;
    expect16("R6 retry resume", outVec, 16'hBEEF);
    expect1("R9 fault held until read", ovFault, 1'b1);
    statusRead = 1'b1; steps(1); statusRead = 1'b0; settle;
    expect1("R9 read clears", ovFault, 1'b0);

    // retry disabled: lock off
    retryEn = 1'b0; ovRaw = 1'b1; steps(N + 1);
    ovRaw = 1'b0; steps(1);
    cmdOut = 16'h00F0; steps(5); settle;
    expect16("R7 locked off", outVec, '0);
    cmdWrite = 1'b1; steps(1); cmdWrite = 1'b0; settle;
    expect16("R7 write releases", outVec, 16'h00F0);

    // load fault alone drives any-fault
    statusRead = 1'b1; steps(1); statusRead = 1'b0;
    loadFault = 1'b1; steps(1); settle;
    expect1("R10 load fault", anyFault, 1'b1);
    expect1("R10 no ov fault", ovFault, 1'b0);
    loadFault = 1'b0;

    // reset during shutdown
    retryEn = 1'b1; ovRaw = 1'b1; steps(N + 3);
    rstN = 1'b0; steps(1); settle;
    expect16("R1 reset in shutdown", outVec, '0);
    expect1("R1 reset clears fault", ovFault, 1'b0);
    ovRaw = 1'b0; rstN = 1'b1; steps(2); settle;
    expect16("R1 fresh start", outVec, 16'h00F0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule